// File: doc/BRIEF.md
# Ping-pong feature buffer with windowed row copy

This block holds the feature maps of one convolution layer in a pipelined accelerator, using two banks of fixed-point words. The compute side writes its results into the collection bank (bank A). Once every map of an image is complete, a copy command moves the contents of bank A into the feed bank (bank B), which supplies the next computation. After the copy has finished, bank A is free to collect the next image while bank B is read, so adjacent layers can work at the same time.

The copy is not a plain block transfer. Every stored row of `ROW_LEN` words is reduced to a shorter destination row as it moves across:

- **Stride 1:** the destination row is a window of `ROW_LEN-2` consecutive words, taken from the start, the middle or the end of the source row. The choice depends on where the nonzero kernel tap sits.
- **Stride 2:** the destination row takes every second word of the source row, from either the even or the odd positions.

The engine moves one word per cycle through a registered read stage. When it finishes, it raises a one-cycle completion pulse.

Top module: `fmap_pingpong_buf`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `busy_o`, `copy_done_o` and `wr_err_o` are all 0.
- R2: When no copy is in progress, asserting `wr_en_i` stores `wr_data_i` into bank A at `wr_addr_i`. `wr_err_o` stays 0 in the following cycle.
- R3: A stride-1 copy (`copy_stride2_i`=0) with offset code k (0, 1 or 2) writes B[r*(ROW_LEN-2)+e] = A[r*ROW_LEN+k+e], for every row r and for e from 0 to ROW_LEN-3.
- R4: A stride-1 copy with offset code 3 gives the same result as offset code 2.
- R5: A stride-2 copy writes B[r*(ROW_LEN/2)+e] = A[r*ROW_LEN+p+2e], for e from 0 to ROW_LEN/2-1. Here p is `copy_phase_i`: 0 selects the even source positions and 1 selects the odd ones. The offset code has no effect in this mode.
- R6: Suppose `copy_start_i` is sampled high at clock edge k while the block is idle, and the copy moves N destination words in total. Then `busy_o` is 1 from edge k onward. `copy_done_o` is high for exactly one cycle, starting at edge k+N+1, which is one cycle after the last write to bank B. In that same cycle `busy_o` returns to 0.
- R7: If `copy_start_i` is asserted while `busy_o` is 1, it is ignored. The running copy keeps its configuration and its timing.
- R8: If `wr_en_i` is asserted while `busy_o` is 1, bank A is left unchanged, and `wr_err_o` is 1 in the following cycle.
- R9: `rd_data_o` shows bank B at `rd_addr_i` one cycle after the address is presented. Bank B words beyond the range a copy writes keep their earlier values.
- R10: Writes into bank A after a copy completes do not change bank B. They appear in bank B only after the next copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Compute-side write strobe into bank A |
| wr_addr_i | input | A_AW | Bank A word address |
| wr_data_i | input | DATA_W | Fixed-point word to store |
| copy_start_i | input | 1 | Starts a copy from bank A to bank B |
| copy_offset_i | input | 2 | Stride-1 window offset code |
| copy_stride2_i | input | 1 | 1 selects stride-2 decimation |
| copy_phase_i | input | 1 | Stride-2 phase: 0 even, 1 odd |
| rd_addr_i | input | B_AW | Bank B read address |
| rd_data_o | output | DATA_W | Bank B read data, one-cycle latency |
| busy_o | output | 1 | Copy in progress |
| copy_done_o | output | 1 | One-cycle pulse when the copy completes |
| wr_err_o | output | 1 | Flags a rejected write made during a copy |

## Verification
The timing of each result is fixed:

- **Bank B reads:** data is due one cycle after the address is presented.
- **Rejected writes:** the error flag is due one cycle after the write.
- **Copy start:** `busy_o` is due right after the start is sampled.
- **Copy completion:** the done pulse is due exactly N+1 cycles after the start is sampled, where N is 4·(ROW_LEN−2) for stride 1 or 4·(ROW_LEN/2) for stride 2.

The bench drives inputs on falling edges and samples on the following falling edge, counting falling edges from the start so that it can require the exact cycle of the done pulse. Bank B contents are compared word by word, after each copy, against a bank model computed in the bench.

// File: rtl/fb_pkg.sv
package fb_pkg;
  typedef struct packed {
    logic [1:0] offset;
    logic       stride2;
    logic       phase;
  } copy_cfg_t;
endpackage

// File: rtl/fb_bank.sv
module fb_bank #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fb_copy_seq.sv
module fb_copy_seq
  import fb_pkg::*;
#(
  parameter int ROW_LEN  = 8,
  parameter int NUM_ROWS = 4,
  parameter int A_AW     = 5,
  parameter int B_AW     = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  copy_cfg_t       cfg_i,
  output logic            active_o,
  output logic [A_AW-1:0] src_o,
  output logic [B_AW-1:0] dst_o,
  output logic            last_o
);
  localparam int EW   = $clog2(ROW_LEN);
  localparam int RW   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int R0   = ROW_LEN - 2;
  localparam int HALF = ROW_LEN / 2;

  copy_cfg_t     cfg_q;
  logic [RW-1:0] row_q;
  logic [EW-1:0] elem_q;
  logic          active_q;
  logic [EW-1:0] dlen_m1;
  logic [1:0]    base;
  logic          row_end;

  always_comb begin
    dlen_m1 = cfg_q.stride2 ? EW'(HALF - 1) : EW'(R0 - 1);
    // stride 2 uses the phase as start position; offset code 3 saturates to 2
    if (cfg_q.stride2)              base = {1'b0, cfg_q.phase};
    else if (cfg_q.offset == 2'd3)  base = 2'd2;
    else                            base = cfg_q.offset;
    src_o = A_AW'(row_q) * A_AW'(ROW_LEN) + A_AW'(base)
          + (cfg_q.stride2 ? A_AW'({elem_q, 1'b0}) : A_AW'(elem_q));
    dst_o = B_AW'(row_q) * (cfg_q.stride2 ? B_AW'(HALF) : B_AW'(R0))
          + B_AW'(elem_q);
    row_end = (elem_q == dlen_m1);
    last_o  = row_end && (row_q == RW'(NUM_ROWS - 1));
  end

  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      row_q    <= '0;
      elem_q   <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cfg_q    <= cfg_i;
      row_q    <= '0;
      elem_q   <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      if (row_end) begin
        elem_q <= '0;
        row_q  <= row_q + RW'(1);
      end else begin
        elem_q <= elem_q + EW'(1);
      end
    end
  end
endmodule

// File: rtl/fb_wr_guard.sv
module fb_wr_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic busy_i,
  output logic we_o,
  output logic err_o
);
  assign we_o = wr_en_i & ~busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= wr_en_i & busy_i;
  end
endmodule

// File: rtl/fmap_pingpong_buf.sv
module fmap_pingpong_buf
  import fb_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ROW_LEN  = 8,
  parameter int NUM_ROWS = 4,
  localparam int A_DEPTH = ROW_LEN * NUM_ROWS,
  localparam int B_DEPTH = (ROW_LEN - 2) * NUM_ROWS,
  localparam int A_AW    = $clog2(A_DEPTH),
  localparam int B_AW    = $clog2(B_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [A_AW-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              copy_start_i,
  input  logic [1:0]        copy_offset_i,
  input  logic              copy_stride2_i,
  input  logic              copy_phase_i,
  input  logic [B_AW-1:0]   rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              copy_done_o,
  output logic              wr_err_o
);
  logic              a_we;
  logic [DATA_W-1:0] a_rdata;
  logic              seq_active, seq_last;
  logic [A_AW-1:0]   seq_src;
  logic [B_AW-1:0]   seq_dst;
  logic              b_we;
  logic [B_AW-1:0]   b_waddr;
  logic              wlast_q, done_q;
  copy_cfg_t         cfg_in;

  assign cfg_in = '{offset: copy_offset_i, stride2: copy_stride2_i, phase: copy_phase_i};
  assign busy_o = seq_active | b_we;
  assign copy_done_o = done_q;

  fb_wr_guard u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .busy_i  (busy_o),
    .we_o    (a_we),
    .err_o   (wr_err_o)
  );

  fb_copy_seq #(
    .ROW_LEN  (ROW_LEN),
    .NUM_ROWS (NUM_ROWS),
    .A_AW     (A_AW),
    .B_AW     (B_AW)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (copy_start_i & ~busy_o),
    .cfg_i    (cfg_in),
    .active_o (seq_active),
    .src_o    (seq_src),
    .dst_o    (seq_dst),
    .last_o   (seq_last)
  );

  fb_bank #(.DATA_W(DATA_W), .DEPTH(A_DEPTH)) u_bank_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (a_we),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (seq_src),
    .rdata_o (a_rdata)
  );

  // destination address and flags follow bank A's registered read by one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_we    <= 1'b0;
      b_waddr <= '0;
      wlast_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      b_we    <= seq_active;
      b_waddr <= seq_dst;
      wlast_q <= seq_active & seq_last;
      done_q  <= b_we & wlast_q;
    end
  end

  fb_bank #(.DATA_W(DATA_W), .DEPTH(B_DEPTH)) u_bank_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (b_we),
    .waddr_i (b_waddr),
    .wdata_i (a_rdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/fb_pingpong_checker.sv
module fb_pingpong_checker #(
  parameter int B_DEPTH = 24,
  parameter int B_AW    = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            copy_done_o,
  input logic            wr_err_o,
  input logic            wr_en_i,
  input logic            copy_start_i,
  input logic            b_we,
  input logic [B_AW-1:0] b_waddr
);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_done_o |=> !copy_done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy_done_o |-> !busy_o);

  assert_busy_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> copy_done_o);

  assert_start_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_start_i && !busy_o) |=> busy_o);

  assert_err_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && busy_o) |=> wr_err_o);

  assert_b_addr_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_we |-> ({1'b0, b_waddr} < (B_AW + 1)'(B_DEPTH)));
endmodule

bind fmap_pingpong_buf fb_pingpong_checker #(.B_DEPTH(B_DEPTH), .B_AW(B_AW)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .copy_done_o  (copy_done_o),
  .wr_err_o     (wr_err_o),
  .wr_en_i      (wr_en_i),
  .copy_start_i (copy_start_i),
  .b_we         (b_we),
  .b_waddr      (b_waddr)
);

// File: tb/fmap_pingpong_buf_tb_top.sv
`timescale 1ns/1ps
module fmap_pingpong_buf_tb_top;
  localparam int DW = 8, RL = 8, NR = 4;
  localparam int AD = RL * NR, BD = (RL - 2) * NR;
  localparam int AAW = $clog2(AD), BAW = $clog2(BD);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 0, copy_start = 0, copy_stride2 = 0, copy_phase = 0;
  logic [AAW-1:0] wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [1:0]     copy_offset = '0;
  logic [BAW-1:0] rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic busy, done, err;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [DW-1:0] a_m [AD];
  logic [DW-1:0] b_m [BD];

  always #2 clk = ~clk;

  fmap_pingpong_buf #(.DATA_W(DW), .ROW_LEN(RL), .NUM_ROWS(NR)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .copy_start_i(copy_start), .copy_offset_i(copy_offset),
    .copy_stride2_i(copy_stride2), .copy_phase_i(copy_phase), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .busy_o(busy), .copy_done_o(done), .wr_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int words_of(input bit s2);
    return NR * (s2 ? RL / 2 : RL - 2);
  endfunction

  function automatic int src_of(input int r, input int e, input logic [1:0] off,
                                input bit s2, input bit ph);
    if (s2) return r * RL + int'(ph) + 2 * e;
    return r * RL + ((off == 2'd3) ? 2 : int'(off)) + e;
  endfunction

  task automatic write_a(input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AAW'(addr); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    chk(err == 1'b0, "R2 err after idle write", int'(err), 0);
    a_m[addr] = d;
  endtask

  task automatic fill_a(input int count);
    for (int i = 0; i < count; i++) begin
      int addr;
      addr = (count == AD) ? i : int'($urandom_range(AD - 1));
      write_a(addr, DW'($urandom));
    end
  endtask

  task automatic do_copy(input logic [1:0] off, input bit s2, input bit ph, input bit inject);
    int n, idx, ia;
    n = words_of(s2);
    @(negedge clk);
    copy_start = 1; copy_offset = off; copy_stride2 = s2; copy_phase = ph;
    @(negedge clk);
    copy_start = 0;
    chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
    idx = 0;
    ia = 0;
    while (!done && idx < 200) begin
      if (inject && idx == 2) begin
        // R7 second start with a different config, R8 write while busy
        copy_start = 1; copy_offset = ~off; copy_stride2 = ~s2; copy_phase = ~ph;
        ia = int'($urandom_range(AD - 1));
        wr_en = 1; wr_addr = AAW'(ia); wr_data = a_m[ia] ^ 8'hA5;
      end
      @(negedge clk);
      idx++;
      copy_start = 0; wr_en = 0;
      if (inject && idx == 3) chk(err == 1'b1, "R8 err flag", int'(err), 1);
    end
    chk(idx == n + 1, "R6 done cycle", idx, n + 1);
    chk(busy == 1'b0, "R6 busy low at done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
    for (int r = 0; r < NR; r++)
      for (int e = 0; e < n / NR; e++)
        b_m[r * (n / NR) + e] = a_m[src_of(r, e, off, s2, ph)];
  endtask

  task automatic check_b(input string req, input int written);
    for (int i = 0; i < BD; i++) begin
      @(negedge clk);
      rd_addr = BAW'(i);
      @(negedge clk);
      if (i >= written) chk(rd_data === b_m[i], "R9 word kept", int'(rd_data), int'(b_m[i]));
      else              chk(rd_data === b_m[i], req, int'(rd_data), int'(b_m[i]));
    end
  endtask

  initial begin
    int seed;
    seed = int'($urandom(32'd1337));
    repeat (3) @(negedge clk);
    chk({busy, done, err} == 3'b000, "R1 reset outputs", int'({busy, done, err}), 0);
    rst_ni = 1;
    @(negedge clk);
    chk({busy, done, err} == 3'b000, "R1 after release", int'({busy, done, err}), 0);

    fill_a(AD);
    do_copy(2'd0, 0, 0, 1); check_b("R3 offset0 window", words_of(0));
    do_copy(2'd1, 0, 0, 0); check_b("R3 offset1 window", words_of(0));
    fill_a(AD);
    do_copy(2'd2, 0, 0, 1); check_b("R3 offset2 window", words_of(0));
    do_copy(2'd3, 0, 0, 0); check_b("R4 offset3 as 2", words_of(0));
    fill_a(AD);
    do_copy(2'd1, 1, 0, 0); check_b("R5 even phase", words_of(1));
    do_copy(2'd2, 1, 1, 1); check_b("R5 odd phase", words_of(1));

    fill_a(AD);
    check_b("R10 bank B untouched", BD);
    do_copy(2'd0, 0, 0, 0); check_b("R10 after next copy", words_of(0));

    for (int it = 0; it < 8; it++) begin
      logic [1:0] off;
      bit s2, ph, inj;
      off = 2'($urandom); s2 = 1'($urandom); ph = 1'($urandom); inj = 1'($urandom);
      fill_a(6);
      do_copy(off, s2, ph, inj);
      check_b(s2 ? "R5 random stride2" : "R3 random stride1", words_of(s2));
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule